// File: doc/BRIEF.md
# I2C Register-Access Slave Interface

This block is an I2C target that lets a bus master read and write a small internal register file. A fast system clock oversamples SCL and SDA. The block finds START, repeated START and STOP conditions from those samples. It answers to a 7-bit device address. The upper six bits of that address are a parameter (default `001100`) and the lowest bit comes from a strap input. SDA is open-drain: the block only asserts an output enable that pulls the line low.

After the block acknowledges its address with the direction bit at 0, the master sends a sub-address byte:

- Bits 6:0 load the register pointer.
- Bit 7 turns auto-increment on or off for the rest of the transaction.

Each later data byte is written to the pointed register. A read is done in three steps:

1. The master sets the pointer with a write-direction phase.
2. The master issues a repeated START.
3. The master sends the address with the direction bit at 1, and the block shifts register contents out MSB first.

The register file itself lives outside the block. The block drives a pointer, a one-cycle write strobe and write data. It takes read data back combinationally from the pointed register.

Top module: `i2c_regif_slave`

## Requirements
- R1: The first byte after a START is acknowledged exactly when its upper seven bits equal `{6'b001100, addr_strap_i}`. With the strap at 0 the accepted bytes are 0x30 (write) and 0x31 (read); with the strap at 1 they are 0x32 and 0x33.
- R2: After a non-matching address byte the block drives SDA on no later clock and issues no register write until the next START or STOP.
- R3: After a write-direction address, the next byte is acknowledged and its bits 6:0 become the register pointer. Each following data byte produces exactly one single-cycle `reg_we_o` pulse while SCL is low, with that byte on `reg_wdata_o` and the pointer on `reg_addr_o`.
- R4: When bit 7 of the sub-address is 1, the pointer advances by one after every data byte, written or read, and wraps from 0x7F to 0x00.
- R5: When bit 7 of the sub-address is 0, every data byte of a write burst goes to the same register.
- R6: A read-direction address after a repeated START returns the pointed register MSB first. With auto-increment on, a burst returns consecutive registers.
- R7: With auto-increment off, every byte of a read burst returns the same register.
- R8: A NACK from the master after a read byte ends the transfer. SDA stays released, and later bytes are neither driven nor acknowledged until a START or STOP.
- R9: Every byte the block receives (address on a match, sub-address, data) is acknowledged, with SDA held low for the whole SCL-high time of the ninth clock.
- R10: The SDA output enable changes only while SCL is low, except when a START or STOP forces a release.
- R11: A STOP releases SDA. The next START begins a fresh address phase that works normally.
- R12: While reset is asserted and right after it, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_strap_i | input | 1 | Lowest bit of the device address |
| reg_addr_o | output | 7 | Register pointer |
| reg_wdata_o | output | 8 | Write data for the pointed register |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Contents of the pointed register |

## Verification
A corrupted bit counter or state shows up at the ports within one byte time. The acknowledge lands on the wrong clock, or a strobe fires a bit early, so the next acknowledge sample disagrees with the master's expectation. A wrong pointer or a lost auto-increment flag stays hidden until the register file is read back. For that reason every write burst is followed by a readback or a direct comparison of the external register image. A full sweep of all address bytes under both strap values shows any mis-decoded address on that byte's own ninth clock.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_regif_sync.sv
module i2c_regif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edge while clock stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_regif_ptr.sv
module i2c_regif_ptr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW:0]   load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic ainc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      ainc_q <= 1'b0;
    end else if (load_i) begin
      ptr_o  <= load_val_i[AW-1:0];
      ainc_q <= load_val_i[AW];
    end else if (step_i && ainc_q) begin
      ptr_o  <= ptr_o + AW'(1);
    end
  end
endmodule

// File: rtl/i2c_regif_slave.sv
module i2c_regif_slave
  import i2c_regif_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_strap_i,
  output logic [6:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int BYTE_W = 8;
  localparam int REG_AW = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  slv_state_e         state_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q, shift_in, wdata_q;
  logic               rw_q, nack_q, oe_q, we_q;
  logic               byte_done, addr_hit, ptr_load, ptr_step;
  logic [REG_AW-1:0]  ptr;

  i2c_regif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign byte_done = (bit_cnt_q == CNT_W'(BYTE_W));
  assign shift_in  = {shreg_q[BYTE_W-2:0], sda_s};
  assign addr_hit  = (shreg_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_strap_i});

  // pointer moves after a stored byte or after the last bit of a sent byte
  assign ptr_load = (state_q == ST_SUB) && scl_fall && byte_done && !start_det && !stop_det;
  assign ptr_step = we_q || ((state_q == ST_RD) && scl_fall && byte_done && !start_det && !stop_det);

  i2c_regif_ptr #(.AW(REG_AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (shreg_q),
    .step_i     (ptr_step),
    .ptr_o      (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      wdata_q   <= '0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_WR: begin
            if (scl_rise && !byte_done) begin
              shreg_q   <= shift_in;
              bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end else if (scl_fall && byte_done) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  rw_q    <= shreg_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else if (state_q == ST_SUB) begin
                oe_q    <= 1'b1;
                state_q <= ST_SUB_ACK;
              end else begin
                oe_q    <= 1'b1;
                we_q    <= 1'b1;
                wdata_q <= shreg_q;
                state_q <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                shreg_q <= reg_rdata_i;
                oe_q    <= ~reg_rdata_i[BYTE_W-1];
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise && !byte_done) begin
              bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end else if (scl_fall) begin
              if (byte_done) begin
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_RD_ACK;
              end else begin
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                oe_q    <= ~shreg_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state_q <= ST_SKIP;
              end else begin
                shreg_q <= reg_rdata_i;
                oe_q    <= ~reg_rdata_i[BYTE_W-1];
                state_q <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
endmodule

// File: rtl/i2c_regif_chk.sv
module i2c_regif_chk
  import i2c_regif_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s_i,
  input logic       start_i,
  input logic       stop_i,
  input slv_state_e state_i,
  input logic       sda_oe_i,
  input logic       reg_we_i
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> (!$past(scl_s_i) || $past(start_i) || $past(stop_i))); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i); // R11

  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SKIP) |-> (!sda_oe_i && !reg_we_i)); // R2

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !reg_we_i); // R3

  AST_WE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> !scl_s_i); // R3

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_ADDR_ACK || state_i == ST_SUB_ACK || state_i == ST_WR_ACK) && scl_s_i)
      |-> sda_oe_i); // R9
endmodule

bind i2c_regif_slave i2c_regif_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .state_i  (state_q),
  .sda_oe_i (sda_oe_o),
  .reg_we_i (reg_we_o)
);

// File: tb/i2c_regif_slave_tb.sv
`timescale 1ns/1ps
module i2c_regif_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda_low, strap;
  logic sda_oe;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_we;
  logic sda_bus;
  logic [7:0] rf [128];
  logic [7:0] exp_rf [128];
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus   = !(m_sda_low || sda_oe);
  assign reg_rdata = rf[reg_addr];

  i2c_regif_slave u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (m_scl),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .addr_strap_i (strap),
    .reg_addr_o   (reg_addr),
    .reg_wdata_o  (reg_wdata),
    .reg_we_o     (reg_we),
    .reg_rdata_i  (reg_rdata)
  );

  // external register file image
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) rf[i] <= 8'(i * 7 + 3);
      wr_cnt <= 0;
    end else if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // R10: enable must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && prev_scl && m_scl && (sda_oe != prev_oe)) oe_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp_v);
    end
  endtask

  task automatic bus_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda_low = 1'b0; bus_wait(Q);
    m_scl = 1'b1;     bus_wait(Q);
    m_sda_low = 1'b1; bus_wait(Q);
    m_scl = 1'b0;     bus_wait(Q);
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1; bus_wait(Q);
    m_scl = 1'b1;     bus_wait(Q);
    m_sda_low = 1'b0; bus_wait(Q);
  endtask

  task automatic m_wbit(input bit b);
    m_sda_low = !b; bus_wait(Q);
    m_scl = 1'b1;   bus_wait(2 * Q);
    m_scl = 1'b0;   bus_wait(Q);
  endtask

  task automatic m_rbit(output bit b, output bit held);
    bit first;
    m_sda_low = 1'b0; bus_wait(Q);
    m_scl = 1'b1;     bus_wait(1);
    first = sda_bus;  bus_wait(2 * Q - 2);
    b = sda_bus;      bus_wait(1);
    m_scl = 1'b0;     bus_wait(Q);
    held = (first == b);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output bit ack, output bit steady);
    bit b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b, steady);
    ack = !b;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input bit nack);
    bit b, h;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b, h);
      d[i] = b;
    end
    m_wbit(nack);
  endtask

  initial begin
    bit ack, st;
    logic [7:0] rd;
    int w0, mism;
    for (int i = 0; i < 128; i++) exp_rf[i] = 8'(i * 7 + 3);
    m_scl = 1'b1; m_sda_low = 1'b0; strap = 1'b0; rst_n = 1'b0;
    bus_wait(5);
    chk("R12 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    bus_wait(3);
    chk("R12 oe after reset", int'(sda_oe), 0);
    chk("R12 no write", wr_cnt, 0);

    // R1 R3 R4 R9: strap 0, auto-increment burst at 0x10
    strap = 1'b0;
    m_start;
    m_wbyte(8'h30, ack, st);
    chk("R1 ack 0x30", int'(ack), 1);
    chk("R9 addr ack held", int'(st), 1);
    m_wbyte(8'h90, ack, st);
    chk("R3 sub ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      m_wbyte(8'hA0 + 8'(k), ack, st);
      chk("R9 data ack", int'(ack & st), 1);
      exp_rf[16 + k] = 8'hA0 + 8'(k);
    end
    m_stop;
    chk("R11 released after stop", int'(sda_oe), 0);
    for (int k = 0; k < 4; k++) chk("R4 burst write", int'(rf[16 + k]), int'(exp_rf[16 + k]));

    // R4 wrap 0x7F -> 0x00, strap 1
    strap = 1'b1;
    m_start;
    m_wbyte(8'h32, ack, st);
    chk("R1 ack 0x32", int'(ack), 1);
    m_wbyte(8'hFF, ack, st);
    m_wbyte(8'h5A, ack, st);
    m_wbyte(8'h5B, ack, st);
    m_stop;
    exp_rf[127] = 8'h5A; exp_rf[0] = 8'h5B;
    chk("R4 wrap top", int'(rf[127]), 'h5A);
    chk("R4 wrap zero", int'(rf[0]), 'h5B);

    // R5 fixed pointer
    m_start;
    m_wbyte(8'h32, ack, st);
    m_wbyte(8'h05, ack, st);
    m_wbyte(8'h11, ack, st);
    m_wbyte(8'h22, ack, st);
    m_wbyte(8'h33, ack, st);
    m_stop;
    exp_rf[5] = 8'h33;
    chk("R5 last byte kept", int'(rf[5]), 'h33);
    chk("R5 neighbour untouched", int'(rf[6]), int'(exp_rf[6]));

    // R6 read burst with increment
    m_start;
    m_wbyte(8'h32, ack, st);
    m_wbyte(8'h90, ack, st);
    m_start;
    m_wbyte(8'h33, ack, st);
    chk("R1 ack 0x33", int'(ack & st), 1);
    for (int k = 0; k < 4; k++) begin
      m_rbyte(rd, k == 3);
      chk("R6 read burst", int'(rd), int'(exp_rf[16 + k]));
    end
    m_stop;

    // R7 read without increment, strap 0
    strap = 1'b0;
    m_start;
    m_wbyte(8'h30, ack, st);
    m_wbyte(8'h05, ack, st);
    m_start;
    m_wbyte(8'h31, ack, st);
    chk("R1 ack 0x31", int'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      m_rbyte(rd, k == 2);
      chk("R7 same register", int'(rd), int'(exp_rf[5]));
    end
    m_stop;

    // R8 NACK ends read
    m_start;
    m_wbyte(8'h30, ack, st);
    m_wbyte(8'h80, ack, st);
    m_start;
    m_wbyte(8'h31, ack, st);
    m_rbyte(rd, 1'b1);
    chk("R8 byte before nack", int'(rd), int'(exp_rf[0]));
    m_rbyte(rd, 1'b1);
    chk("R8 silent after nack", int'(rd), 'hFF);
    w0 = wr_cnt;
    m_wbyte(8'h30, ack, st);
    chk("R8 no ack after nack", int'(ack), 0);
    m_stop;
    chk("R8 no write after nack", wr_cnt, w0);
    m_start;
    m_wbyte(8'h30, ack, st);
    chk("R11 fresh transaction", int'(ack), 1);
    m_stop;

    // R2 mismatched address
    strap = 1'b1;
    w0 = wr_cnt;
    m_start;
    m_wbyte(8'h30, ack, st);
    chk("R2 no ack 0x30 strap1", int'(ack), 0);
    m_wbyte(8'h05, ack, st);
    chk("R2 no ack sub", int'(ack), 0);
    m_wbyte(8'h77, ack, st);
    chk("R2 no ack data", int'(ack), 0);
    m_stop;
    chk("R2 no write", wr_cnt, w0);
    m_start;
    m_wbyte(8'h31, ack, st);
    chk("R2 no ack read 0x31 strap1", int'(ack), 0);
    m_rbyte(rd, 1'b1);
    chk("R2 bus idle high", int'(rd), 'hFF);
    m_stop;

    // R1 R2 full address sweep under both straps
    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      for (int a = 0; a < 128; a++) begin
        m_start;
        m_wbyte({a[6:0], 1'b0}, ack, st);
        chk((a == 24 + s) ? "R1 sweep hit" : "R2 sweep miss", int'(ack), (a == 24 + s) ? 1 : 0);
        m_stop;
      end
    end
    chk("R2 no write in sweep", wr_cnt, w0);

    mism = 0;
    for (int i = 0; i < 128; i++) if (rf[i] !== exp_rf[i]) mism++;
    chk("R3 register image", mism, 0);
    chk("R10 oe moved with SCL high", oe_viol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0x0 expected 0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule